// File: doc/BRIEF.md
# Interrupt Acknowledge Bus Sequencer

This block is the processor-side engine that fetches an interrupt type from an external priority controller over an 8-bit multiplexed bus. When it takes a request it runs two acknowledge bus cycles, one right after the other. Each cycle is timed like a read. The acknowledge strobe takes the place of the read strobe, and the address drivers are switched off. The byte on the data bus is not used in the first cycle. In the second cycle the controller drives the interrupt type, and the block latches it. It then shifts the type left by two to form a byte address into the vector table.

The sequencer gives a one-clock valid pulse with the finished table address. It also drives a transceiver-disable output. When the controller sits on the local side of the data buffers, this output keeps the buffered system bus off the data lines while the type byte is read. Instruction execution and the table fetch that follows are left to other logic.

Top module: `iack_seq`

## Requirements
- R1: In each acknowledge cycle the ack strobe (`ackStrobe`, active high) is high in T2, in T3 and in every wait state, and low in T1 and T4. `readStrobe` stays low at all times.
- R2: `addrOe` is low from T1 of the first cycle through T4 of the second cycle, including the idle gap. It is high in the idle state and in the valid clock.
- R3: Each accepted request produces exactly two acknowledge cycles. They are separated by `GAP_LEN` idle clocks (default 1), during which the strobe is low.
- R4: The data bus value during the first cycle is ignored: `vecAddr` keeps its previous value through the first cycle and the gap.
- R5: The type byte is sampled only in the second cycle, at the clock edge that ends T3 or a wait state with `ready` high. Data present at other clocks of that cycle, including T4, has no effect.
- R6: `vecAddr` (10 bits) equals the sampled type times four, which is `{type, 2'b00}`. It holds that value until the next capture.
- R7: `ready` low at the end of T3 or of a wait state inserts a further wait state, and the strobe stays high. `ready` is ignored in all other states.
- R8: `xcvrDisable` is high exactly while the strobe is high in the second cycle and `ctrlLocal` is high. It is low at all other times.
- R9: `vecValid` is high for exactly one clock, the clock after T4 of the second cycle. `irqReq` is ignored in that clock. A request seen in the idle state starts T1 on the next clock.
- R10: After reset the block is idle: `addrOe` is high, the strobes, `xcvrDisable` and `vecValid` are low, and `vecAddr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqReq | input | 1 | Interrupt request level |
| ready | input | 1 | Bus ready; low inserts wait states |
| ctrlLocal | input | 1 | High when the interrupt controller is on the local bus |
| dataIn | input | 8 | Data bus input |
| ackStrobe | output | 1 | Interrupt acknowledge strobe, active high |
| readStrobe | output | 1 | Read strobe, held inactive by this block |
| addrOe | output | 1 | Address bus output enable; low floats the address |
| xcvrDisable | output | 1 | Disables the system-bus data transceiver |
| vecAddr | output | 10 | Vector table byte address |
| vecValid | output | 1 | One-clock pulse when vecAddr is new |

## Verification
The hardest case to reach from the ports is a type byte that appears on the bus only at the single clock where ready closes the second cycle. Around that clock, differing junk appears while ready is low and again in T4. The bench tracks the expected bus phase itself, with no help from the design. It drives ready low for a random number of wait states in each cycle and places the true type byte only at the expected sampling clock, so a capture one clock early or late yields a wrong address. Directed runs cover zero waits, long waits, the type values 0x00 and 0xFF, and a request held high through the valid pulse.

// File: rtl/iack_pkg.sv
package iack_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_T1, PH_T2, PH_T3, PH_TW, PH_T4, PH_GAP, PH_DONE
  } busPhase_t;

  typedef struct packed {
    logic captureType;
    logic ackOn;
    logic secondCyc;
  } dpCtl_t;

endpackage

// File: rtl/iack_ctrl.sv
module iack_ctrl
  import iack_pkg::*;
#(
  parameter int GAP_LEN = 1
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   irqReq,
  input  logic   ready,
  output dpCtl_t ctl,
  output logic   addrFloat,
  output logic   vecValid
);
  localparam int GAP_W = (GAP_LEN < 2) ? 1 : $clog2(GAP_LEN + 1);

  busPhase_t phase, phaseNext;
  logic secondCyc, secondNext;
  logic [GAP_W-1:0] gapCnt, gapNext;

  always_comb begin
    phaseNext  = phase;
    secondNext = secondCyc;
    gapNext    = gapCnt;
    unique case (phase)
      PH_IDLE: if (irqReq) begin
        phaseNext  = PH_T1;
        secondNext = 1'b0;
      end
      PH_T1:   phaseNext = PH_T2;
      PH_T2:   phaseNext = PH_T3;
      PH_T3,
      PH_TW:   phaseNext = ready ? PH_T4 : PH_TW;
      PH_T4: begin
        if (secondCyc) phaseNext = PH_DONE;
        else begin
          phaseNext = PH_GAP;
          gapNext   = GAP_W'(GAP_LEN - 1);
        end
      end
      PH_GAP: begin
        if (gapCnt == '0) begin
          phaseNext  = PH_T1;
          secondNext = 1'b1;
        end else begin
          gapNext = gapCnt - 1'b1;
        end
      end
      PH_DONE: phaseNext = PH_IDLE;
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      secondCyc <= 1'b0;
      gapCnt    <= '0;
    end else begin
      phase     <= phaseNext;
      secondCyc <= secondNext;
      gapCnt    <= gapNext;
    end
  end

  always_comb begin
    ctl.ackOn       = (phase == PH_T2) || (phase == PH_T3) || (phase == PH_TW);
    ctl.secondCyc   = secondCyc;
    ctl.captureType = secondCyc && ready && ((phase == PH_T3) || (phase == PH_TW));
    addrFloat       = (phase != PH_IDLE) && (phase != PH_DONE);
    vecValid        = (phase == PH_DONE);
  end

endmodule

// File: rtl/iack_dp.sv
module iack_dp
  import iack_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SCALE_SH = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpCtl_t                 ctl,
  input  logic                   ctrlLocal,
  input  logic [DATA_W-1:0]      dataIn,
  output logic [DATA_W+SCALE_SH-1:0] vecAddr,
  output logic                   xcvrDisable
);
  logic [DATA_W-1:0] typeReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                typeReg <= '0;
    else if (ctl.captureType) typeReg <= dataIn;
  end

  assign vecAddr     = {typeReg, {SCALE_SH{1'b0}}};
  assign xcvrDisable = ctl.ackOn && ctl.secondCyc && ctrlLocal;

endmodule

// File: rtl/iack_seq.sv
module iack_seq
  import iack_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SCALE_SH = 2,
  parameter int GAP_LEN  = 1,
  localparam int ADDR_W  = DATA_W + SCALE_SH
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              irqReq,
  input  logic              ready,
  input  logic              ctrlLocal,
  input  logic [DATA_W-1:0] dataIn,
  output logic              ackStrobe,
  output logic              readStrobe,
  output logic              addrOe,
  output logic              xcvrDisable,
  output logic [ADDR_W-1:0] vecAddr,
  output logic              vecValid
);
  dpCtl_t ctl;
  logic   addrFloat;

  iack_ctrl #(.GAP_LEN(GAP_LEN)) ctrl_i (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .ready(ready),
    .ctl(ctl), .addrFloat(addrFloat), .vecValid(vecValid)
  );

  iack_dp #(.DATA_W(DATA_W), .SCALE_SH(SCALE_SH)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .ctrlLocal(ctrlLocal),
    .dataIn(dataIn), .vecAddr(vecAddr), .xcvrDisable(xcvrDisable)
  );

  assign ackStrobe  = ctl.ackOn;
  assign readStrobe = 1'b0;
  assign addrOe     = !addrFloat;

endmodule

// File: rtl/iack_chk.sv
module iack_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              ready,
  input logic              ctrlLocal,
  input logic              ackStrobe,
  input logic              addrOe,
  input logic              xcvrDisable,
  input logic [ADDR_W-1:0] vecAddr,
  input logic              vecValid
);

  assert_float_R2: assert property (@(posedge clk) disable iff (!rstN)
    ackStrobe |-> !addrOe);

  assert_t1_first_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackStrobe) |-> $past(!addrOe));

  assert_wait_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && !ready) |=> ackStrobe);

  assert_xcvr_R8: assert property (@(posedge clk) disable iff (!rstN)
    xcvrDisable |-> (ackStrobe && ctrlLocal));

  assert_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |=> !vecValid);

  assert_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> (!ackStrobe && addrOe));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |=> $stable(vecAddr));

endmodule

bind iack_seq iack_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/iack_seq_tb.sv
module iack_seq_tb_top;
  localparam int P_T1 = 1, P_T2 = 2, P_T3 = 3, P_TW = 4, P_T4 = 5, P_GAP = 6, P_DONE = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic irqReq = 1'b0, ready = 1'b1, ctrlLocal = 1'b0;
  logic [7:0] dataIn = '0;
  logic ackStrobe, readStrobe, addrOe, xcvrDisable, vecValid;
  logic [9:0] vecAddr;
  int checks = 0, fails = 0;
  logic [9:0] prevAddr = '0;
  bit finished = 0;

  always #2 clk = ~clk;

  iack_seq dut_i (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .ready(ready), .ctrlLocal(ctrlLocal),
    .dataIn(dataIn), .ackStrobe(ackStrobe), .readStrobe(readStrobe), .addrOe(addrOe),
    .xcvrDisable(xcvrDisable), .vecAddr(vecAddr), .vecValid(vecValid)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [9:0] expAddr(logic [7:0] t);
    return 10'(t) * 10'd4;
  endfunction

  task automatic checkPhase(int ph, bit second, bit loc);
    logic ack = (ph == P_T2) || (ph == P_T3) || (ph == P_TW);
    chk("R1", "ackStrobe", ackStrobe, ack);
    chk("R1", "readStrobe", readStrobe, 1'b0);
    chk((ph == P_GAP) ? "R3" : "R2", "addrOe", addrOe, (ph == P_DONE));
    chk("R8", "xcvrDisable", xcvrDisable, ack && second && loc);
    chk("R9", "vecValid", vecValid, (ph == P_DONE));
  endtask

  task automatic oneCycle(bit second, int waits, logic [7:0] typ, bit loc);
    @(negedge clk); checkPhase(P_T1, second, loc); dataIn = 8'($urandom); ready = 1'($urandom);
    @(negedge clk); checkPhase(P_T2, second, loc); dataIn = 8'($urandom); ready = 1'($urandom);
    @(negedge clk); checkPhase(P_T3, second, loc);
    ready  = (waits == 0);
    dataIn = (second && waits == 0) ? typ : ~typ;
    for (int k = 1; k <= waits; k++) begin
      @(negedge clk); checkPhase(P_TW, second, loc);
      chk("R7", "strobe held in wait", ackStrobe, 1'b1);
      ready  = (k == waits);
      dataIn = (second && k == waits) ? typ : (typ ^ 8'(k));
    end
    @(negedge clk); checkPhase(P_T4, second, loc);
    dataIn = ~typ; ready = 1'($urandom);
    if (!second) chk("R4", "vecAddr after first cycle", vecAddr, prevAddr);
  endtask

  task automatic runTxn(logic [7:0] typ, int w1, int w2, bit loc);
    @(negedge clk);
    irqReq = 1'b1; ctrlLocal = loc; dataIn = typ; ready = 1'($urandom);
    oneCycle(1'b0, w1, typ, loc);
    @(negedge clk); checkPhase(P_GAP, 1'b0, loc);
    chk("R4", "vecAddr in gap", vecAddr, prevAddr);
    oneCycle(1'b1, w2, typ, loc);
    @(negedge clk); checkPhase(P_DONE, 1'b1, loc);
    chk("R6", "vecAddr", vecAddr, expAddr(typ));
    chk("R5", "type low bits zero", vecAddr[1:0], 2'b00);
    @(negedge clk);
    chk("R9", "idle after valid despite irq", addrOe, 1'b1);
    chk("R9", "no strobe after valid", ackStrobe, 1'b0);
    chk("R6", "vecAddr held", vecAddr, expAddr(typ));
    irqReq = 1'b0;
    @(negedge clk);
    chk("R9", "stays idle without irq", addrOe, 1'b1);
    prevAddr = expAddr(typ);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R10", "addrOe", addrOe, 1'b1);
    chk("R10", "ackStrobe", ackStrobe, 1'b0);
    chk("R10", "vecValid", vecValid, 1'b0);
    chk("R10", "vecAddr", vecAddr, 10'd0);
    chk("R10", "xcvrDisable", xcvrDisable, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10", "idle after release", addrOe, 1'b1);
    runTxn(8'hFF, 0, 0, 1'b1);
    runTxn(8'h00, 0, 0, 1'b0);
    runTxn(8'hA5, 5, 0, 1'b1);
    runTxn(8'h3C, 0, 6, 1'b1);
    runTxn(8'h81, 3, 2, 1'b0);
    for (int n = 0; n < 60; n++)
      runTxn(8'($urandom), int'($urandom_range(0, 4)), int'($urandom_range(0, 4)),
             1'($urandom));
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule